// File: doc/BRIEF.md
# Four-Client Bus Arbiter with Selectable Priority Mode

This block shares one internal bus among four clients: the input stream reader, the reference picture reader, the decoded output writer and the post-processed output writer. At any time it grants the bus to at most one of them, and the grant is a one-hot vector. A 3-bit mode input selects how a winner is chosen. Four modes use fixed rankings, and the remaining values use a rotating, round-robin search.

A grant is registered, so it appears on the cycle after the decision that made it. It stays locked on its owner until that owner pulses its done line. The grant then drops for one cycle, and the next decision is taken on that idle cycle. The mode input is sampled only when a decision is taken, so changing it while a transaction is open has no effect on the current owner.

Top module: `arb_mode_top`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, gnt_o is 4'b0000.
- R2: gnt_o never has more than one bit set. Bit 0 is the input stream reader, bit 1 is the reference reader, bit 2 is the decoded output writer and bit 3 is the post-processed output writer. req_i and done_i use the same bit positions.
- R3: When gnt_o is zero and req_i is non-zero at a clock edge, gnt_o on the next cycle is one of the bits that was requested at that edge.
- R4: While gnt_o is non-zero and the owner's done_i bit is low, gnt_o keeps its value on the next cycle, whatever req_i and mode_i do.
- R5: When the owner's done_i bit is high at a clock edge, gnt_o is zero on the next cycle.
- R6: When gnt_o is zero and req_i is zero, gnt_o stays zero.
- R7: In mode 1, the ranking is post-processed writer, then input reader, then reference reader, then decoded writer.
- R8: In mode 2, the ranking is input reader, then reference reader, then decoded writer, then post-processed writer.
- R9: In mode 3, the ranking is reference reader, then post-processed writer, then input reader, then decoded writer.
- R10: In mode 4, the ranking is reference reader, then decoded writer, then input reader, then post-processed writer.
- R11: In mode 0, the search begins at the client after the one granted last, in bit order and wrapping around. After reset it begins at bit 0.
- R12: Modes 5, 6 and 7 behave the same as mode 0.
- R13: A mode change while a grant is held does not affect that grant. The new mode applies from the next decision onward.
- R14: A done_i pulse from a client that does not hold the grant is ignored: gnt_o does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Priority mode select |
| req_i | input | 4 | Request, one bit per client |
| done_i | input | 4 | End-of-transaction pulse, one bit per client |
| gnt_o | output | 4 | One-hot grant |

## Verification
Two kinds of collision matter here. The first is the owner's done pulse arriving in the same cycle as a change of mode and fresh requests. The second is a non-owner's done pulse arriving while the grant is locked. The bench provokes both: it changes mode_i and req_i in the same cycle as the release, and it pulses done_i bits of non-owners during held grants. A behavioural model, built from queues of rankings, predicts gnt_o on every cycle. It checks that the release yields exactly one idle cycle and that the winner follows the mode sampled on that idle cycle, not the mode in force when the transaction began.

// File: rtl/arb_mode_pkg.sv
package arb_mode_pkg;
  localparam int unsigned N_CLIENTS = 4;
  localparam int unsigned IDX_W     = $clog2(N_CLIENTS);
  localparam int unsigned MODE_W    = 3;

  typedef logic [IDX_W-1:0] cidx_t;

  typedef enum logic [IDX_W-1:0] {
    CL_IN_RD  = 2'd0,
    CL_REF_RD = 2'd1,
    CL_DEC_WR = 2'd2,
    CL_PP_WR  = 2'd3
  } client_e;

  typedef enum logic [MODE_W-1:0] {
    MD_ROTATE  = 3'd0,
    MD_PP_TOP  = 3'd1,
    MD_IN_TOP  = 3'd2,
    MD_REF_PP  = 3'd3,
    MD_REF_DEC = 3'd4
  } mode_e;

  function automatic logic mode_is_fixed(logic [MODE_W-1:0] m);
    return (m >= MD_PP_TOP) && (m <= MD_REF_DEC);
  endfunction
endpackage

// File: rtl/arb_rank_table.sv
module arb_rank_table
  import arb_mode_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output cidx_t             order_o [N_CLIENTS]
);
  // up to two leading clients, then the rest in default (index) order
  cidx_t lead0, lead1;
  int    n_lead;

  always_comb begin
    lead0  = CL_IN_RD;
    lead1  = CL_IN_RD;
    n_lead = 0;
    unique case (mode_i)
      MD_PP_TOP:  begin lead0 = CL_PP_WR;  n_lead = 1; end
      MD_IN_TOP:  begin lead0 = CL_IN_RD;  n_lead = 1; end
      MD_REF_PP:  begin lead0 = CL_REF_RD; lead1 = CL_PP_WR;  n_lead = 2; end
      MD_REF_DEC: begin lead0 = CL_REF_RD; lead1 = CL_DEC_WR; n_lead = 2; end
      default:    n_lead = 0;
    endcase
  end

  always_comb begin
    int pos;
    for (int p = 0; p < N_CLIENTS; p++) order_o[p] = cidx_t'(p);
    pos = 0;
    if (n_lead >= 1) begin order_o[0] = lead0; pos = 1; end
    if (n_lead >= 2) begin order_o[1] = lead1; pos = 2; end
    for (int c = 0; c < N_CLIENTS; c++) begin
      if (!((n_lead >= 1 && cidx_t'(c) == lead0) ||
            (n_lead >= 2 && cidx_t'(c) == lead1))) begin
        if (pos < N_CLIENTS) order_o[pos] = cidx_t'(c);
        pos = pos + 1;
      end
    end
  end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick
  import arb_mode_pkg::*;
(
  input  logic [N_CLIENTS-1:0] req_i,
  input  cidx_t                order_i [N_CLIENTS],
  output logic [N_CLIENTS-1:0] pick_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int p = 0; p < N_CLIENTS; p++) begin
      if (!found && req_i[order_i[p]]) begin
        pick_o[order_i[p]] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
  import arb_mode_pkg::*;
(
  input  logic [N_CLIENTS-1:0] req_i,
  input  cidx_t                last_i,
  output logic [N_CLIENTS-1:0] pick_o
);
  always_comb begin
    logic  found;
    cidx_t idx;
    found  = 1'b0;
    pick_o = '0;
    for (int k = 1; k <= N_CLIENTS; k++) begin
      idx = cidx_t'((int'(last_i) + k) % N_CLIENTS);
      if (!found && req_i[idx]) begin
        pick_o[idx] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_mode_top.sv
module arb_mode_top
  import arb_mode_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [N_CLIENTS-1:0] req_i,
  input  logic [N_CLIENTS-1:0] done_i,
  output logic [N_CLIENTS-1:0] gnt_o
);
  logic [N_CLIENTS-1:0] gnt_q, fix_pick, rr_pick, pick;
  cidx_t                last_q, pick_idx;
  cidx_t                order [N_CLIENTS];
  logic                 busy, decide, release_own;

  arb_rank_table u_rank (.mode_i(mode_i), .order_o(order));

  arb_fixed_pick u_fix (.req_i(req_i), .order_i(order), .pick_o(fix_pick));

  arb_rr_pick u_rr (.req_i(req_i), .last_i(last_q), .pick_o(rr_pick));

  assign busy        = |gnt_q;
  assign decide      = !busy && (|req_i);
  assign release_own = |(gnt_q & done_i);
  assign pick        = mode_is_fixed(mode_i) ? fix_pick : rr_pick;

  always_comb begin
    pick_idx = '0;
    for (int c = 0; c < N_CLIENTS; c++)
      if (pick[c]) pick_idx = cidx_t'(c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= cidx_t'(N_CLIENTS - 1);
    end else if (busy) begin
      if (release_own) gnt_q <= '0;
    end else if (decide) begin
      gnt_q  <= pick;
      last_q <= pick_idx;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/arb_mode_chk.sv
module arb_mode_chk
  import arb_mode_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [MODE_W-1:0]    mode_i,
  input logic [N_CLIENTS-1:0] req_i,
  input logic [N_CLIENTS-1:0] done_i,
  input logic [N_CLIENTS-1:0] gnt_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2
  AST_GNT_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i != '0) |=> ((gnt_o & $past(req_i)) != '0)); // R3
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (gnt_o & done_i) == '0) |=> (gnt_o == $past(gnt_o))); // R4
  AST_GNT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & done_i) != '0) |=> (gnt_o == '0)); // R5
  AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0)); // R6
  AST_MODE1_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && mode_i == 3'd1 && req_i[3]) |=> (gnt_o == 4'b1000)); // R7
  AST_MODE2_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && mode_i == 3'd2 && req_i[0]) |=> (gnt_o == 4'b0001)); // R8
  AST_MODE3_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && mode_i == 3'd3 && req_i[1]) |=> (gnt_o == 4'b0010)); // R9
  AST_MODE4_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && mode_i == 3'd4 && req_i[1]) |=> (gnt_o == 4'b0010)); // R10
endmodule

bind arb_mode_top arb_mode_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mode_i(mode_i),
  .req_i (req_i),
  .done_i(done_i),
  .gnt_o (gnt_o)
);

// File: tb/tb_arb_mode_top.sv
`timescale 1ns/100ps
module tb_arb_mode_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [3:0] req = 4'b0;
  logic [3:0] done = 4'b0;
  logic [3:0] gnt;

  int n_tests = 0, n_fail = 0;
  string tag = "R1";

  // model state
  int m_owner = -1;
  int m_last  = 3;

  always #2.5 clk = ~clk;

  arb_mode_top dut (.clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
                    .req_i(req), .done_i(done), .gnt_o(gnt));

  function automatic int model_pick(int md, logic [3:0] r, int last);
    int q[$];
    case (md)
      1: q = '{3, 0, 1, 2};
      2: q = '{0, 1, 2, 3};
      3: q = '{1, 3, 0, 2};
      4: q = '{1, 2, 0, 3};
      default: begin
        q = {};
        for (int k = 1; k <= 4; k++) q.push_back((last + k) % 4);
      end
    endcase
    foreach (q[i]) if (r[q[i]]) return q[i];
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = -1;
      m_last  = 3;
    end else if (m_owner >= 0) begin
      if (done[m_owner]) m_owner = -1;
    end else if (req != 4'b0) begin
      m_owner = model_pick(int'(mode), req, m_last);
      m_last  = m_owner;
    end
  end

  function automatic logic [3:0] exp_gnt();
    return (m_owner < 0) ? 4'b0 : 4'(1 << m_owner);
  endfunction

  task automatic check(logic [3:0] exp, string t);
    n_tests++;
    if (gnt !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt_o=%b expected=%b", t, gnt, exp);
    end
  endtask

  // sample at negedge, then drive inputs for the next edge
  task automatic step(logic [3:0] r, logic [3:0] d, logic [2:0] m);
    @(negedge clk);
    check(exp_gnt(), tag);
    req = r; done = d; mode = m;
  endtask

  function automatic logic [3:0] own_done();
    return (m_owner < 0) ? 4'b0 : 4'(1 << m_owner);
  endfunction

  // all four requesting; cycle through grants, releasing each right away
  task automatic drain(logic [2:0] m, int n);
    for (int i = 0; i < n; i++) begin
      step(4'b1111, 4'b0, m);
      step(4'b1111, own_done(), m);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #7;
    tag = "R1"; check(4'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(4'b0, 4'b0, 3'd0);
    check(4'b0, "R1");

    tag = "R6";
    for (int i = 0; i < 4; i++) step(4'b0, 4'b0, 3'd1);

    // mode 0 rotation: 0,1,2,3,0
    tag = "R11";
    step(4'b1111, 4'b0, 3'd0);
    step(4'b1111, 4'b0, 3'd0);
    check(4'b0001, "R11");
    step(4'b1111, 4'b0001, 3'd0);
    drain(3'd0, 4);

    tag = "R7";  drain(3'd1, 3);
    tag = "R8";  drain(3'd2, 3);
    tag = "R9";  drain(3'd3, 3);
    tag = "R10"; drain(3'd4, 3);

    // mode 3 with only input and decoder requesting: input wins
    tag = "R9";
    step(4'b0101, 4'b0, 3'd3);
    step(4'b0101, 4'b0, 3'd3);
    check(4'b0001, "R9");
    step(4'b0, own_done(), 3'd3);
    step(4'b0, 4'b0, 3'd3);

    tag = "R12";
    drain(3'd5, 4);
    drain(3'd6, 4);
    drain(3'd7, 4);

    // R13: mode change mid transaction; R14: non-owner done ignored
    tag = "R13";
    step(4'b0001, 4'b0, 3'd2);
    step(4'b1111, 4'b0, 3'd2);
    check(4'b0001, "R13");
    step(4'b1111, 4'b0, 3'd1);
    step(4'b1111, 4'b0, 3'd4);
    check(4'b0001, "R13");
    tag = "R14";
    step(4'b1111, 4'b1110, 3'd4);
    step(4'b1111, 4'b0, 3'd4);
    check(4'b0001, "R14");
    // release together with mode change: mode 1 sampled on the idle cycle
    tag = "R5";
    step(4'b1111, 4'b0001, 3'd4);
    step(4'b1111, 4'b0, 3'd1);
    check(4'b0, "R5");
    tag = "R13";
    step(4'b1111, 4'b0, 3'd1);
    check(4'b1000, "R13");
    step(4'b0, own_done(), 3'd0);
    step(4'b0, 4'b0, 3'd0);

    // mixed stimulus: varying requests, modes and stray done pulses
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r, d;
      r = 4'($urandom);
      d = 4'($urandom) & ~own_done();
      if ($urandom % 3 == 0) d = d | own_done();
      step(r, d, 3'($urandom));
    end
    step(4'b0, own_done(), 3'd0);
    step(4'b0, 4'b0, 3'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule